// File: doc/BRIEF.md
# PLL bring-up sequencer

This block steps a frequency-multiplying PLL through its power-up and power-down. The PLL feeds a four-channel synthesizer. An enable request starts bring-up, one step per clock. The block first takes the PLL out of soft reset, then writes the noise-bandwidth selection, then writes the multiplier code, and last drives the power-down line to its "running" level. After that it watches the lock indication until lock arrives or a cycle-counted timeout expires. A disable request powers the PLL down and, one clock later, puts it back into soft reset.

Each instance can leave out the soft-reset step, the bandwidth step or the lock wait. Each feature that is left out skips its state. The power-down line has a polarity parameter. The block reports whether the PLL is powered, whether it is locked, and whether the last lock wait timed out. It also reports the multiplication factor now in effect, which is the 3-bit code plus 16.

States are `ST_OFF`, `ST_REL_RST`, `ST_SET_BW`, `ST_SET_MULT`, `ST_PWR_UP`, `ST_WAIT_LOCK`, `ST_RUN`, `ST_NO_LOCK`, `ST_PWR_DN` and `ST_HOLD_RST`. The transitions are:
- `ST_OFF` goes to the first present bring-up step on a taken or queued enable.
- `ST_REL_RST` goes to `ST_SET_BW`, or to `ST_SET_MULT` when the bandwidth step is absent.
- `ST_SET_BW` goes to `ST_SET_MULT`.
- `ST_SET_MULT` goes to `ST_PWR_UP`.
- `ST_PWR_UP` goes to `ST_WAIT_LOCK`, or to `ST_RUN` when the lock wait is absent.
- `ST_WAIT_LOCK` goes to `ST_PWR_DN` on a disable, to `ST_RUN` on lock, or to `ST_NO_LOCK` on timer expiry, in that priority.
- `ST_RUN` and `ST_NO_LOCK` go to `ST_PWR_DN` on a disable.
- `ST_PWR_DN` goes to `ST_HOLD_RST`, or to `ST_OFF` when the reset step is absent.
- `ST_HOLD_RST` goes to `ST_OFF`.

Top module: `pll_bringup_seq`

## Requirements
- R1: During and after reset the PLL is held in soft reset (`pll_soft_rst_n`=0 when the reset feature is present), `pll_pwrdn` is at its power-down level, `pll_mult_code` is 0, and `enabled_o`, `locked_o` and `timeout_err_o` are 0.
- R2: `mult_factor_o` equals `pll_mult_code` plus 16. The code written to the PLL is the `mult_code_in` value sampled at the edge that takes or queues the enable request. The code does not change while the PLL stays powered.
- R3: Bring-up takes one step per clock, in this order: release soft reset, write bandwidth code 0 (good reference), write the multiplier code, power up. With all features present, `enabled_o` rises on the fourth rising edge after the edge that takes the request. At that moment soft reset is released and the bandwidth code is 0.
- R4: In the lock wait, `pll_lock_in` high sets `locked_o`. `locked_o` then stays set while the PLL remains powered, and is never set while it is unpowered.
- R5: If lock is not seen within TIMEOUT_CYC cycles of waiting, `timeout_err_o` is set, `locked_o` stays 0 and the PLL stays powered.
- R6: `timeout_err_o` stays set through a disable. It is cleared on the edge that takes the next enable request.
- R7: Tear-down first drives `pll_pwrdn` to its power-down level and clears `locked_o`, then one clock later asserts soft reset.
- R8: With PWRDN_POL=1 the PLL runs while `pll_pwrdn` is 0. With PWRDN_POL=0 it runs while `pll_pwrdn` is 1. `enabled_o` is 1 exactly when `pll_pwrdn` is at the running level.
- R9: Without the reset feature, `pll_soft_rst_n` is held at 1. Without the lock feature, `locked_o` is set at power-up with no wait. Without the bandwidth feature, that step is skipped and `pll_bw_sel` stays 0.
- R10: An enable request that arrives while power-down or reset-assert is in progress is queued. Bring-up starts once the block is back in `ST_OFF`.
- R11: An enable request during bring-up or while powered has no effect, and the multiplier code stays as it was. A disable request while off has no effect. A disable request during the bring-up steps is held and applied once the PLL has been powered up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable_req | input | 1 | One-cycle request to bring the PLL up |
| disable_req | input | 1 | One-cycle request to take the PLL down |
| mult_code_in | input | MULT_W | Multiplier code for the next bring-up |
| pll_lock_in | input | 1 | Lock indication from the PLL |
| pll_soft_rst_n | output | 1 | PLL soft reset, low = held in reset |
| pll_bw_sel | output | 2 | Reference-noise bandwidth code (0 good, 1 very bad, 2 bad, 3 very good) |
| pll_mult_code | output | MULT_W | Multiplier code driven to the PLL |
| pll_pwrdn | output | 1 | Power-down control, polarity set by PWRDN_POL |
| enabled_o | output | 1 | PLL powered |
| locked_o | output | 1 | Lock observed since the last power-up |
| timeout_err_o | output | 1 | Last lock wait timed out |
| mult_factor_o | output | FACT_W | Effective multiplication factor |

## Verification
A wrong state register shows up at the ports within one or two clocks. It may skip a bring-up step, so the PLL powers up on the wrong edge or with reset still asserted, and the exact-edge check catches that. It may swap the tear-down order, so soft reset falls while `enabled_o` is still high. A broken timer or lock path leaves `locked_o` and `timeout_err_o` wrong once the lock window has passed. A lost queued enable or held disable leaves `enabled_o` at the wrong level once the block has settled.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

    typedef enum logic [3:0] {
        ST_OFF,
        ST_REL_RST,
        ST_SET_BW,
        ST_SET_MULT,
        ST_PWR_UP,
        ST_WAIT_LOCK,
        ST_RUN,
        ST_NO_LOCK,
        ST_PWR_DN,
        ST_HOLD_RST
    } seq_state_t;

    // reference-noise bandwidth codes
    localparam logic [1:0] BW_GOOD_REF      = 2'd0;
    localparam logic [1:0] BW_VERY_BAD_REF  = 2'd1;
    localparam logic [1:0] BW_BAD_REF       = 2'd2;
    localparam logic [1:0] BW_VERY_GOOD_REF = 2'd3;

endpackage

// File: rtl/pll_lock_timer.sv
module pll_lock_timer #(
    parameter int TIMEOUT_CYC = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    output logic expired
);
    localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYC - 1);

    logic [CNT_W-1:0] cnt_q;

    assign expired = arm && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!arm) begin
            cnt_q <= '0;
        end else if (!expired) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/pll_seq_ctrl.sv
module pll_seq_ctrl
    import pll_seq_pkg::*;
#(
    parameter int MULT_W     = 3,
    parameter int PWRDN_POL  = 1,
    parameter int HAS_RESET  = 1,
    parameter int HAS_BWFILT = 1,
    parameter int HAS_LOCK   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable_req,
    input  logic              disable_req,
    input  logic [MULT_W-1:0] mult_code_in,
    input  logic              lock_in,
    input  logic              timer_expired,
    output logic              timer_arm,
    output logic              soft_rst_n,
    output logic [1:0]        bw_sel,
    output logic [MULT_W-1:0] mult_code,
    output logic              pwrdn,
    output logic              locked,
    output logic              timeout_err
);
    localparam logic OFF_LVL = (PWRDN_POL != 0);
    localparam logic ON_LVL  = !OFF_LVL;
    localparam logic RST_INIT = (HAS_RESET == 0);
    localparam seq_state_t AFTER_RST  = (HAS_BWFILT != 0) ? ST_SET_BW : ST_SET_MULT;
    localparam seq_state_t FIRST_STEP = (HAS_RESET != 0) ? ST_REL_RST : AFTER_RST;
    localparam seq_state_t AFTER_PWR  = (HAS_LOCK != 0) ? ST_WAIT_LOCK : ST_RUN;
    localparam seq_state_t AFTER_PD   = (HAS_RESET != 0) ? ST_HOLD_RST : ST_OFF;

    seq_state_t        st_q, st_nxt;
    logic              pend_en_q, pend_dis_q;
    logic [MULT_W-1:0] req_code_q;
    logic              start, go_down, in_bringup, in_teardown;

    assign in_bringup  = (st_q == ST_REL_RST) || (st_q == ST_SET_BW) ||
                         (st_q == ST_SET_MULT) || (st_q == ST_PWR_UP);
    assign in_teardown = (st_q == ST_PWR_DN) || (st_q == ST_HOLD_RST);
    assign start       = (st_q == ST_OFF) && (enable_req || pend_en_q);
    assign go_down     = disable_req || pend_dis_q;
    assign timer_arm   = (st_q == ST_WAIT_LOCK);

    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            ST_OFF:       if (start) st_nxt = FIRST_STEP;
            ST_REL_RST:   st_nxt = AFTER_RST;
            ST_SET_BW:    st_nxt = ST_SET_MULT;
            ST_SET_MULT:  st_nxt = ST_PWR_UP;
            ST_PWR_UP:    st_nxt = AFTER_PWR;
            ST_WAIT_LOCK: begin
                if (go_down)            st_nxt = ST_PWR_DN;
                else if (lock_in)       st_nxt = ST_RUN;
                else if (timer_expired) st_nxt = ST_NO_LOCK;
            end
            ST_RUN,
            ST_NO_LOCK:   if (go_down) st_nxt = ST_PWR_DN;
            ST_PWR_DN:    st_nxt = AFTER_PD;
            ST_HOLD_RST:  st_nxt = ST_OFF;
            default:      st_nxt = ST_OFF;
        endcase
    end

    // state register and held requests
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= ST_OFF;
            pend_en_q  <= 1'b0;
            pend_dis_q <= 1'b0;
        end else begin
            st_q <= st_nxt;
            if (st_q == ST_OFF)
                pend_en_q <= 1'b0;
            else if (enable_req && in_teardown)
                pend_en_q <= 1'b1;
            if ((st_q == ST_PWR_DN) || (st_q == ST_OFF))
                pend_dis_q <= 1'b0;
            else if (disable_req && in_bringup)
                pend_dis_q <= 1'b1;
        end
    end

    // actions taken in each state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            soft_rst_n  <= RST_INIT;
            bw_sel      <= BW_GOOD_REF;
            mult_code   <= '0;
            pwrdn       <= OFF_LVL;
            locked      <= 1'b0;
            timeout_err <= 1'b0;
            req_code_q  <= '0;
        end else begin
            if (enable_req && ((st_q == ST_OFF) || in_teardown))
                req_code_q <= mult_code_in;
            unique case (st_q)
                ST_OFF:       if (start) timeout_err <= 1'b0;
                ST_REL_RST:   soft_rst_n <= 1'b1;
                ST_SET_BW:    bw_sel <= BW_GOOD_REF;
                ST_SET_MULT:  mult_code <= req_code_q;
                ST_PWR_UP: begin
                    pwrdn <= ON_LVL;
                    if (HAS_LOCK == 0) locked <= 1'b1;
                end
                ST_WAIT_LOCK: begin
                    if (!go_down) begin
                        if (lock_in)            locked <= 1'b1;
                        else if (timer_expired) timeout_err <= 1'b1;
                    end
                end
                ST_RUN, ST_NO_LOCK: ;
                ST_PWR_DN: begin
                    pwrdn  <= OFF_LVL;
                    locked <= 1'b0;
                end
                ST_HOLD_RST:  soft_rst_n <= 1'b0;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/pll_bringup_seq.sv
module pll_bringup_seq #(
    parameter int MULT_W      = 3,
    parameter int MULT_BASE   = 16,
    parameter int TIMEOUT_CYC = 1024,
    parameter int PWRDN_POL   = 1,
    parameter int HAS_RESET   = 1,
    parameter int HAS_BWFILT  = 1,
    parameter int HAS_LOCK    = 1,
    parameter int FACT_W      = $clog2(MULT_BASE + (1 << MULT_W))
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable_req,
    input  logic              disable_req,
    input  logic [MULT_W-1:0] mult_code_in,
    input  logic              pll_lock_in,
    output logic              pll_soft_rst_n,
    output logic [1:0]        pll_bw_sel,
    output logic [MULT_W-1:0] pll_mult_code,
    output logic              pll_pwrdn,
    output logic              enabled_o,
    output logic              locked_o,
    output logic              timeout_err_o,
    output logic [FACT_W-1:0] mult_factor_o
);
    localparam logic RUN_LVL = (PWRDN_POL == 0);

    logic timer_arm, timer_expired;

    pll_lock_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (timer_arm),
        .expired (timer_expired)
    );

    pll_seq_ctrl #(
        .MULT_W     (MULT_W),
        .PWRDN_POL  (PWRDN_POL),
        .HAS_RESET  (HAS_RESET),
        .HAS_BWFILT (HAS_BWFILT),
        .HAS_LOCK   (HAS_LOCK)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .enable_req    (enable_req),
        .disable_req   (disable_req),
        .mult_code_in  (mult_code_in),
        .lock_in       (pll_lock_in),
        .timer_expired (timer_expired),
        .timer_arm     (timer_arm),
        .soft_rst_n    (pll_soft_rst_n),
        .bw_sel        (pll_bw_sel),
        .mult_code     (pll_mult_code),
        .pwrdn         (pll_pwrdn),
        .locked        (locked_o),
        .timeout_err   (timeout_err_o)
    );

    assign enabled_o     = (pll_pwrdn == RUN_LVL);
    assign mult_factor_o = FACT_W'(pll_mult_code) + FACT_W'(MULT_BASE);
endmodule

// File: rtl/pll_bringup_seq_chk.sv
module pll_bringup_seq_chk #(
    parameter int MULT_W    = 3,
    parameter int HAS_RESET = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enabled_o,
    input logic              locked_o,
    input logic              timeout_err_o,
    input logic              pll_soft_rst_n,
    input logic [1:0]        pll_bw_sel,
    input logic [MULT_W-1:0] pll_mult_code
);
    assert_bringup_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(enabled_o) |-> (pll_soft_rst_n && (pll_bw_sel == 2'd0)));

    assert_rst_only_when_down_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pll_soft_rst_n) |-> !enabled_o);

    assert_lock_needs_power_R4: assert property (@(posedge clk) disable iff (!rst_n)
        locked_o |-> enabled_o);

    assert_timeout_not_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_err_o |-> !locked_o);

    assert_timeout_powered_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_err_o) |-> enabled_o);

    assert_mult_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (enabled_o && $past(enabled_o)) |-> $stable(pll_mult_code));

    if (HAS_RESET != 0) begin : g_rst
        assert_rst_after_pd_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(enabled_o) |=> !pll_soft_rst_n);
    end
endmodule

bind pll_bringup_seq pll_bringup_seq_chk #(
    .MULT_W    (MULT_W),
    .HAS_RESET (HAS_RESET)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .enabled_o      (enabled_o),
    .locked_o       (locked_o),
    .timeout_err_o  (timeout_err_o),
    .pll_soft_rst_n (pll_soft_rst_n),
    .pll_bw_sel     (pll_bw_sel),
    .pll_mult_code  (pll_mult_code)
);

// File: tb/test_pll_bringup_seq.sv
module test_pll_bringup_seq;
    localparam int TMO = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable_req = 1'b0;
    logic       disable_req = 1'b0;
    logic [2:0] mult_code_in = 3'd0;
    logic       pll_lock_in;

    logic       soft_rst_n, pwrdn, enabled, locked, tmo_err;
    logic [1:0] bw_sel;
    logic [2:0] mcode;
    logic [4:0] mfact;

    logic       a_soft_rst_n, a_pwrdn, a_enabled, a_locked, a_tmo_err;
    logic [1:0] a_bw_sel;
    logic [2:0] a_mcode;
    logic [4:0] a_mfact;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int lock_delay = 0;
    bit lock_never = 1'b0;
    int pw_cnt = 0;
    int exp_code = 0;
    logic prev_en = 1'b0, prev_rst = 1'b0;

    always #4 clk = ~clk;

    pll_bringup_seq #(.TIMEOUT_CYC(TMO)) i_pll_bringup_seq (
        .clk(clk), .rst_n(rst_n), .enable_req(enable_req), .disable_req(disable_req),
        .mult_code_in(mult_code_in), .pll_lock_in(pll_lock_in),
        .pll_soft_rst_n(soft_rst_n), .pll_bw_sel(bw_sel), .pll_mult_code(mcode),
        .pll_pwrdn(pwrdn), .enabled_o(enabled), .locked_o(locked),
        .timeout_err_o(tmo_err), .mult_factor_o(mfact)
    );

    pll_bringup_seq #(.TIMEOUT_CYC(TMO), .PWRDN_POL(0), .HAS_RESET(0),
                      .HAS_BWFILT(0), .HAS_LOCK(0)) i_pll_bringup_seq_alt (
        .clk(clk), .rst_n(rst_n), .enable_req(enable_req), .disable_req(disable_req),
        .mult_code_in(mult_code_in), .pll_lock_in(1'b0),
        .pll_soft_rst_n(a_soft_rst_n), .pll_bw_sel(a_bw_sel), .pll_mult_code(a_mcode),
        .pll_pwrdn(a_pwrdn), .enabled_o(a_enabled), .locked_o(a_locked),
        .timeout_err_o(a_tmo_err), .mult_factor_o(a_mfact)
    );

    // PLL model: lock rises lock_delay cycles after power-up
    always @(posedge clk) pw_cnt <= enabled ? pw_cnt + 1 : 0;
    assign pll_lock_in = enabled && !lock_never && (pw_cnt >= lock_delay);

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int factor_of(input int code);
        return code + 16;
    endfunction

    // ordering monitors, sampled away from the clock edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (enabled && !prev_en) begin
                check("R3 ready at power-up", int'(soft_rst_n && bw_sel == 2'd0), 1);
                check("R2 code at power-up", int'(mcode), exp_code);
            end
            if (prev_rst && !soft_rst_n)
                check("R7 powered down before reset", int'(prev_en), 0);
            if (enabled)
                check("R8 pwrdn low while running", int'(pwrdn), 0);
        end
        prev_en  = enabled;
        prev_rst = soft_rst_n;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic do_enable(input int code);
        @(negedge clk);
        enable_req   = 1'b1;
        mult_code_in = 3'(code);
        @(negedge clk);
        enable_req = 1'b0;
    endtask

    task automatic do_disable();
        @(negedge clk);
        disable_req = 1'b1;
        @(negedge clk);
        disable_req = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd20240611);

        // R1 reset state
        idle(3);
        check("R1 soft reset held", int'(soft_rst_n), 0);
        check("R1 pwrdn at off level", int'(pwrdn), 1);
        check("R1 enabled/locked/timeout clear", int'({enabled, locked, tmo_err}), 0);
        check("R1 code zero", int'(mcode), 0);
        rst_n = 1'b1;
        idle(2);

        // R11 disable while off
        do_disable();
        idle(3);
        check("R11 disable while off", int'({soft_rst_n, enabled, pwrdn}), 1);

        // R3 exact edge of power-up, R4 lock
        lock_never = 1'b0; lock_delay = 3; exp_code = 5;
        do_enable(5);
        idle(3);
        check("R3 not powered before 4th edge", int'(enabled), 0);
        idle(1);
        check("R3 powered on 4th edge", int'(enabled), 1);
        idle(20);
        check("R4 locked", int'(locked), 1);
        check("R2 factor", int'(mfact), factor_of(5));
        check("R9 alt no reset: held released", int'(a_soft_rst_n), 1);
        check("R9 alt no lock: locked at once", int'(a_locked), 1);
        check("R8 alt running level high", int'(a_pwrdn), 1);

        // R11 enable while running is ignored
        do_enable(1);
        idle(10);
        check("R11 code unchanged", int'(mfact), factor_of(5));

        // R10 enable queued during disable
        exp_code = 2;
        do_disable();
        do_enable(2);
        idle(40);
        check("R10 queued enable powered", int'(enabled), 1);
        check("R10 queued code", int'(mfact), factor_of(2));
        do_disable();
        idle(5);
        check("R7 off after disable", int'({enabled, locked, soft_rst_n}), 0);
        check("R8 alt off level low", int'(a_pwrdn), 0);

        // R5/R6 timeout, sticky flag
        lock_never = 1'b1; exp_code = 7;
        do_enable(7);
        idle(60);
        check("R5 timeout set", int'(tmo_err), 1);
        check("R5 not locked", int'(locked), 0);
        check("R5 stays powered", int'(enabled), 1);
        do_disable();
        idle(5);
        check("R6 timeout kept after disable", int'(tmo_err), 1);
        lock_never = 1'b0; lock_delay = 2; exp_code = 4;
        do_enable(4);
        check("R6 cleared on enable", int'(tmo_err), 0);
        idle(30);
        check("R4 locked after retry", int'(locked), 1);
        do_disable();
        idle(5);

        // R11 disable during bring-up is held
        exp_code = 3;
        do_enable(3);
        do_disable();
        idle(40);
        check("R11 held disable applied", int'(enabled), 0);
        check("R11 held disable reset", int'(soft_rst_n), 0);

        // random runs
        for (int it = 0; it < 24; it++) begin
            int code, mode;
            code = int'($urandom % 8);
            mode = int'($urandom % 3);
            lock_never = (mode == 2);
            lock_delay = (mode == 0) ? int'($urandom % 11) : 80 + int'($urandom % 40);
            exp_code = code;
            do_enable(code);
            idle(60);
            check("R2 factor random", int'(mfact), factor_of(code));
            check("R4 lock random", int'(locked), (mode == 0) ? 1 : 0);
            check("R5 timeout random", int'(tmo_err), (mode == 0) ? 0 : 1);
            check("R5 powered random", int'(enabled), 1);
            check("R9 alt locked random", int'(a_locked), 1);
            do_disable();
            idle(4);
            check("R7 down random", int'({enabled, locked, soft_rst_n}), 0);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule